// File: doc/BRIEF.md
# Queue Status Flag Bus Controller

This block presents the per-queue status of one multi-queue FIFO device on two shared, active-low flag buses. The write-side bus carries almost-full status and runs on the write clock. The read-side bus runs on the read clock and carries either almost-empty status or packet-ready status. Several devices sit on the same buses, and each device places its bus drivers in high impedance whenever it is not the one reporting.

Two strap inputs are sampled while reset is held. The first strap picks the reporting scheme. In direct mode, a strobe and a device address choose which device reports. In polled mode, a free-running counter steps through every device index. The second strap picks what the read-side bus means. In packet mode, it reports which queues hold at least one end-of-packet word, and a separate packet-ready flag for the selected read queue becomes active. Each device is wired with its own index, and the buses reach it through the interconnect of the device group.

Top module: `qflag_bus`

## Requirements
- R1: Each bus is 8 bits wide. When the bus is driven, bit i (i = 0..3) is the inverse of queue i's status (0 means the condition holds), and bits 7..4 are 1.
- R2: The flag-mode strap (0 = direct, 1 = polled) and the packet strap (1 = packet-ready) are latched on every clock edge that sees reset high. After reset, changing either strap has no effect.
- R3: In direct mode, a clock edge with the strobe high captures whether the address equals devId. The bus is driven from that edge on, and this choice holds through edges where the strobe is low.
- R4: While the device is selected, each edge loads the status present at that edge, so the bus shows it one cycle later.
- R5: In polled mode, an internal counter starts at 0 after reset. It advances on every edge and wraps from NUM_DEV-1 to 0. The bus is driven during the cycle that follows an edge at which the counter equalled devId.
- R6: With the packet strap latched as 0, read-side status is qAlmostEmpty. With it latched as 1, queue i's status is (its end-of-packet count != 0).
- R7: pktRdyN is registered. It equals the inverse of queue rdQSel's packet-ready status when packet mode is latched. Otherwise it is held at 1.
- R8: During and straight after reset, both buses are high impedance and pktRdyN is 1. A bus that is not driven is high impedance.
- R9: The write-side and read-side buses are selected independently, each by its own strobe and address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous master reset, active high |
| flagModeStrap | input | 1 | 0 = direct, 1 = polled; sampled during reset |
| pktStrap | input | 1 | 1 = packet-ready content; sampled during reset |
| devId | input | DEV_W | Index of this device in the group |
| wrStrobe | input | 1 | Write-side select strobe (direct mode) |
| wrAddr | input | DEV_W | Write-side device address |
| rdStrobe | input | 1 | Read-side select strobe (direct mode) |
| rdAddr | input | DEV_W | Read-side device address |
| qAlmostFull | input | NUM_Q | Per-queue almost-full, active high |
| qAlmostEmpty | input | NUM_Q | Per-queue almost-empty, active high |
| eopCnt | input | NUM_Q*CNT_W | Per-queue end-of-packet word counts |
| rdQSel | input | QSEL_W | Queue selected for reads |
| afBus | output | BUS_W | Almost-full flag bus, active low, tri-state |
| aeBus | output | BUS_W | Almost-empty / packet-ready flag bus, active low, tri-state |
| pktRdyN | output | 1 | Packet-ready flag for the read queue, active low |

## Verification
The status load and the change of bus ownership can happen on the same edge. A strobe that selects the device arrives together with new queue status. The bus must then turn on already carrying that status, and not the older value held in the register. The bench provokes this by sweeping every devId in both flag modes and both content modes with random strobes, addresses and status. It compares each bus every cycle against a cycle model, which includes high impedance. Strobes on the write and read sides are drawn independently, so one bus changes owner while the other holds, and each bus is judged separately.

// File: rtl/qflag_pkg.sv
package qflag_pkg;
  typedef struct packed {
    logic load;   // capture fresh status into the bus register
    logic drive;  // this device owns the bus this cycle
  } flag_ctl_t;
endpackage

// File: rtl/qflag_ctrl.sv
module qflag_ctrl
  import qflag_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int DEV_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeStrap,
  input  logic             strobe,
  input  logic [DEV_W-1:0] addr,
  input  logic [DEV_W-1:0] devId,
  output flag_ctl_t        ctl,
  output logic             pollMode
);
  localparam logic [DEV_W-1:0] LastDev = DEV_W'(NUM_DEV - 1);

  logic             pollQ;
  logic             driveQ;
  logic [DEV_W-1:0] cntQ;
  logic             nextDrive;

  always_comb begin
    if (pollQ) nextDrive = (cntQ == devId);
    else if (strobe) nextDrive = (addr == devId);
    else nextDrive = driveQ;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pollQ  <= modeStrap;
      driveQ <= 1'b0;
      cntQ   <= '0;
    end else begin
      driveQ <= nextDrive;
      if (pollQ) cntQ <= (cntQ == LastDev) ? '0 : cntQ + 1'b1;
    end
  end

  assign ctl.load  = !rst && nextDrive;
  assign ctl.drive = driveQ;
  assign pollMode  = pollQ;
endmodule

// File: rtl/qflag_dp.sv
module qflag_dp
  import qflag_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  flag_ctl_t        ctl,
  input  logic [NUM_Q-1:0] stat,
  output logic [BUS_W-1:0] bus
);
  localparam int PadW = BUS_W - NUM_Q;

  logic [BUS_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (rst) dataQ <= '1;
    else if (ctl.load) dataQ <= {{PadW{1'b1}}, ~stat};
  end

  assign bus = ctl.drive ? dataQ : {BUS_W{1'bz}};
endmodule

// File: rtl/qflag_pkt.sv
module qflag_pkt #(
  parameter int NUM_Q  = 4,
  parameter int CNT_W  = 4,
  parameter int QSEL_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   pktStrap,
  input  logic [NUM_Q*CNT_W-1:0] eopCnt,
  input  logic [QSEL_W-1:0]      qSel,
  output logic [NUM_Q-1:0]       ready,
  output logic                   pktMode,
  output logic                   pktRdyN
);
  logic pktQ;

  for (genvar i = 0; i < NUM_Q; i++) begin : g_rdy
    assign ready[i] = |eopCnt[i*CNT_W +: CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pktQ    <= pktStrap;
      pktRdyN <= 1'b1;
    end else begin
      pktRdyN <= pktQ ? ~ready[qSel] : 1'b1;
    end
  end

  assign pktMode = pktQ;
endmodule

// File: rtl/qflag_bus.sv
module qflag_bus
  import qflag_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int NUM_Q   = 4,
  parameter int BUS_W   = 8,
  parameter int CNT_W   = 4,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1
) (
  input  logic                   wrClk,
  input  logic                   rdClk,
  input  logic                   rst,
  input  logic                   flagModeStrap,
  input  logic                   pktStrap,
  input  logic [DEV_W-1:0]       devId,
  input  logic                   wrStrobe,
  input  logic [DEV_W-1:0]       wrAddr,
  input  logic                   rdStrobe,
  input  logic [DEV_W-1:0]       rdAddr,
  input  logic [NUM_Q-1:0]       qAlmostFull,
  input  logic [NUM_Q-1:0]       qAlmostEmpty,
  input  logic [NUM_Q*CNT_W-1:0] eopCnt,
  input  logic [QSEL_W-1:0]      rdQSel,
  output logic [BUS_W-1:0]       afBus,
  output logic [BUS_W-1:0]       aeBus,
  output logic                   pktRdyN
);
  flag_ctl_t        wrCtl, rdCtl;
  logic             wrPoll, rdPoll, pktMode;
  logic [NUM_Q-1:0] readyVec, rdStat;

  qflag_ctrl #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_wrCtrl (
    .clk(wrClk), .rst(rst), .modeStrap(flagModeStrap), .strobe(wrStrobe),
    .addr(wrAddr), .devId(devId), .ctl(wrCtl), .pollMode(wrPoll));

  qflag_ctrl #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) u_rdCtrl (
    .clk(rdClk), .rst(rst), .modeStrap(flagModeStrap), .strobe(rdStrobe),
    .addr(rdAddr), .devId(devId), .ctl(rdCtl), .pollMode(rdPoll));

  qflag_pkt #(.NUM_Q(NUM_Q), .CNT_W(CNT_W), .QSEL_W(QSEL_W)) u_pkt (
    .clk(rdClk), .rst(rst), .pktStrap(pktStrap), .eopCnt(eopCnt),
    .qSel(rdQSel), .ready(readyVec), .pktMode(pktMode), .pktRdyN(pktRdyN));

  assign rdStat = pktMode ? readyVec : qAlmostEmpty;

  qflag_dp #(.NUM_Q(NUM_Q), .BUS_W(BUS_W)) u_wrDp (
    .clk(wrClk), .rst(rst), .ctl(wrCtl), .stat(qAlmostFull), .bus(afBus));

  qflag_dp #(.NUM_Q(NUM_Q), .BUS_W(BUS_W)) u_rdDp (
    .clk(rdClk), .rst(rst), .ctl(rdCtl), .stat(rdStat), .bus(aeBus));
endmodule

// File: rtl/qflag_bus_chk.sv
module qflag_bus_chk #(
  parameter int NUM_DEV = 4,
  parameter int BUS_W   = 8,
  parameter int NUM_Q   = 4,
  parameter int DEV_W   = 2
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             rst,
  input logic             wrPoll,
  input logic             rdPoll,
  input logic             wrDrive,
  input logic             rdDrive,
  input logic             pktMode,
  input logic             pktRdyN,
  input logic             wrStrobe,
  input logic [DEV_W-1:0] wrAddr,
  input logic             rdStrobe,
  input logic [DEV_W-1:0] rdAddr,
  input logic [DEV_W-1:0] devId,
  input logic [BUS_W-1:0] afBus
);
  AST_PAD_HIGH: assert property (@(posedge wrClk) disable iff (rst)
    wrDrive |-> (afBus[BUS_W-1:NUM_Q] == '1)); // R1

  AST_MODE_HELD: assert property (@(posedge wrClk) disable iff (rst)
    1'b1 |=> $stable(wrPoll)); // R2

  AST_WR_DESELECT: assert property (@(posedge wrClk) disable iff (rst)
    (!wrPoll && wrStrobe && wrAddr != devId) |=> !wrDrive); // R3

  AST_RD_SELECT: assert property (@(posedge rdClk) disable iff (rst)
    (!rdPoll && rdStrobe && rdAddr == devId) |=> rdDrive); // R9

  AST_POLL_SINGLE: assert property (@(posedge wrClk) disable iff (rst)
    (NUM_DEV > 1 && wrPoll && wrDrive) |=> !wrDrive); // R5

  AST_PKT_IDLE: assert property (@(posedge rdClk) disable iff (rst)
    !pktMode |-> pktRdyN); // R7
endmodule

bind qflag_bus qflag_bus_chk #(
  .NUM_DEV(NUM_DEV), .BUS_W(BUS_W), .NUM_Q(NUM_Q), .DEV_W(DEV_W)
) u_chk (
  .wrClk(wrClk), .rdClk(rdClk), .rst(rst), .wrPoll(wrPoll), .rdPoll(rdPoll),
  .wrDrive(wrCtl.drive), .rdDrive(rdCtl.drive), .pktMode(pktMode),
  .pktRdyN(pktRdyN), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
  .rdStrobe(rdStrobe), .rdAddr(rdAddr), .devId(devId), .afBus(afBus));

// File: tb/test_qflag_bus.sv
module test_qflag_bus;
  localparam int NDEV = 4;
  localparam int NQ   = 4;
  localparam int BW   = 8;
  localparam int CW   = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst = 1'b1;
  logic          flagModeStrap = 1'b0, pktStrap = 1'b0;
  logic [1:0]    devId = '0, wrAddr = '0, rdAddr = '0, rdQSel = '0;
  logic          wrStrobe = 1'b0, rdStrobe = 1'b0;
  logic [NQ-1:0] qAlmostFull = '0, qAlmostEmpty = '0;
  logic [NQ*CW-1:0] eopCnt = '0;
  wire  [BW-1:0] afBus, aeBus;
  wire           pktRdyN;

  qflag_bus #(.NUM_DEV(NDEV), .NUM_Q(NQ), .BUS_W(BW), .CNT_W(CW)) i_qflag_bus (
    .wrClk(clk), .rdClk(clk), .rst(rst), .flagModeStrap(flagModeStrap),
    .pktStrap(pktStrap), .devId(devId), .wrStrobe(wrStrobe), .wrAddr(wrAddr),
    .rdStrobe(rdStrobe), .rdAddr(rdAddr), .qAlmostFull(qAlmostFull),
    .qAlmostEmpty(qAlmostEmpty), .eopCnt(eopCnt), .rdQSel(rdQSel),
    .afBus(afBus), .aeBus(aeBus), .pktRdyN(pktRdyN));

  int nChk = 0, nFail = 0;

  // bench model state
  logic mPoll, mPkt, mWrDrv, mRdDrv, mPktN;
  logic [1:0] mWrCnt, mRdCnt;
  logic [BW-1:0] mWrData, mRdData;

  task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // model one edge using current inputs
  task automatic model_edge();
    logic wn, rn;
    logic [NQ-1:0] rs;
    if (rst) begin
      mPoll = flagModeStrap; mPkt = pktStrap;
      mWrDrv = 0; mRdDrv = 0; mWrCnt = 0; mRdCnt = 0;
      mWrData = '1; mRdData = '1; mPktN = 1;
    end else begin
      for (int i = 0; i < NQ; i++) rs[i] = mPkt ? (eopCnt[i*CW +: CW] != 0) : qAlmostEmpty[i];
      wn = mPoll ? (mWrCnt == devId) : (wrStrobe ? wrAddr == devId : mWrDrv);
      rn = mPoll ? (mRdCnt == devId) : (rdStrobe ? rdAddr == devId : mRdDrv);
      if (wn) mWrData = {4'hF, ~qAlmostFull};
      if (rn) mRdData = {4'hF, ~rs};
      mWrDrv = wn; mRdDrv = rn;
      if (mPoll) begin
        mWrCnt = (mWrCnt == NDEV - 1) ? 2'd0 : mWrCnt + 2'd1;
        mRdCnt = (mRdCnt == NDEV - 1) ? 2'd0 : mRdCnt + 2'd1;
      end
      mPktN = mPkt ? ~(eopCnt[rdQSel*CW +: CW] != 0) : 1'b1;
    end
  endtask

  task automatic step_and_check();
    string t;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    t = mPoll ? "R5 R1 R2" : "R3 R4 R1 R2";
    check(t, afBus, mWrDrv ? mWrData : {BW{1'bz}});
    check(mPoll ? "R6 R9 R5" : "R6 R9 R3", aeBus, mRdDrv ? mRdData : {BW{1'bz}});
    check("R7", {7'b0, pktRdyN}, {7'b0, mPktN});
  endtask

  task automatic run_cfg(input int dev, input bit poll, input bit pkt);
    devId = 2'(dev);
    rst = 1; flagModeStrap = poll; pktStrap = pkt;
    wrStrobe = 0; rdStrobe = 0;
    for (int c = 0; c < 2; c++) begin
      model_edge();
      @(posedge clk); @(negedge clk);
    end
    // R8: idle after reset
    check("R8", afBus, {BW{1'bz}});
    check("R8", aeBus, {BW{1'bz}});
    check("R8", {7'b0, pktRdyN}, 8'd1);
    rst = 0;
    flagModeStrap = ~poll; pktStrap = ~pkt;  // R2: straps now ignored
    for (int c = 0; c < 28; c++) begin
      wrStrobe = ($urandom_range(2) == 0);
      rdStrobe = ($urandom_range(2) == 0);
      wrAddr = 2'($urandom); rdAddr = 2'($urandom);
      qAlmostFull = 4'($urandom); qAlmostEmpty = 4'($urandom);
      for (int q = 0; q < NQ; q++)
        eopCnt[q*CW +: CW] = ($urandom_range(1) == 0) ? 4'd0 : 4'($urandom);
      rdQSel = 2'($urandom);
      step_and_check();
    end
  endtask

  initial begin
    @(negedge clk);
    for (int d = 0; d < NDEV; d++)
      for (int p = 0; p < 2; p++)
        for (int k = 0; k < 2; k++)
          run_cfg(d, p[0], k[0]);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #200000;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule